// File: doc/BRIEF.md
# Inter-Processor Message Unit

This block sits between two processors, called side A and side B, and lets them exchange 32-bit words and signals. Each side has its own simple register port. Each side owns four outgoing mailbox words. A word written by one side is the word the other side reads from the matching incoming slot. An occupancy bit for each channel pairs the two sides. A write marks the channel occupied. A read by the receiver frees it again. Each side sees this bit as "outgoing slot empty" for its own transmit channels and as "incoming slot full" for its receive channels.

Each side has a control register that holds three things: a separate enable for every empty and full condition, an enable for each general-purpose request, and three flag bits that the other side can read. Each side can also raise four general-purpose requests toward its peer. A request stays pending until the receiver clears it. Any pending request drives a wake output that does not depend on the enables. Each processor gets one interrupt line, which is the OR of its enabled sources. Software can run the block with interrupts, or it can poll the status register.

Top module: `ipc_mailbox`

Register map, per side, by word address (reads return data in the same cycle as the request):

| Address | Name | Read | Write |
|---|---|---|---|
| 0..3 | TXn | own outgoing word n | store word n for the peer |
| 4..7 | RXn | incoming word n (frees channel n) | ignored |
| 8 | STAT | status, see R3 | bits [11:8] write-1-to-clear pending requests |
| 9 | CTRL | control, see R5 | control |
| 10 | GPREQ | 0 | bits [3:0] set peer pending requests |
| other | - | 0 | ignored |

## Requirements
- R1: After reset, STAT reads 0x0000000F on both sides. CTRL reads 0, and irq and wake are 0 on both sides.
- R2: A word written to TXn on one side is returned by a read of RXn on the other side, in both directions. A read of TXn returns the side's own last written word.
- R3: STAT bit n (n = 0..3) is the transmit-empty bit for the side's own channel n, and bit 4+n is the receive-full bit for the incoming channel n. A write to TXn clears the writer's bit n and sets the peer's bit 4+n on the next clock edge.
- R4: A read of RXn clears the reader's STAT bit 4+n and sets the sender's STAT bit n on the next clock edge.
- R5: CTRL bits [7:4] enable the receive-full interrupts. irq is high whenever an enabled receive-full bit is set.
- R6: CTRL bits [3:0] enable the transmit-empty interrupts. irq is high whenever an enabled transmit-empty bit is set.
- R7: CTRL bits [14:12] are the side's flags. The peer reads them in its STAT bits [14:12].
- R8: Writing GPREQ with bits [3:0] sets the peer's pending bits, shown in the peer's STAT [11:8]. They stay set until the peer writes 1 to them in STAT. wake is high while any pending bit is set.
- R9: CTRL bits [11:8] enable the general-purpose interrupts. irq is high whenever an enabled pending bit is set.
- R10: If one side writes TXn in the same cycle that the other side reads RXn, the reader gets the old word. The channel stays full and holds the new word.
- R11: If a pending bit is cleared and newly requested in the same cycle, it stays set.
- R12: Writes to RXn are ignored. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| a_req | input | 1 | side A access strobe |
| a_we | input | 1 | side A write (1) or read (0) |
| a_addr | input | 4 | side A word address |
| a_wdata | input | 32 | side A write data |
| a_rdata | output | 32 | side A read data, valid while a_req is high |
| a_irq | output | 1 | interrupt to processor A |
| a_wake | output | 1 | general-purpose request pending at side A |
| b_req | input | 1 | side B access strobe |
| b_we | input | 1 | side B write (1) or read (0) |
| b_addr | input | 4 | side B word address |
| b_wdata | input | 32 | side B write data |
| b_rdata | output | 32 | side B read data, valid while b_req is high |
| b_irq | output | 1 | interrupt to processor B |
| b_wake | output | 1 | general-purpose request pending at side B |

## Verification
Read data is combinational from the registered state, so it is due in the same cycle as the strobe. The bench drives each access on a falling edge and samples rdata 1 ns later, before the edge that applies the access's side effects. Occupancy, pending bits, irq and wake change on the next rising edge. The bench samples them 1 ns after that edge and compares them with a model that it updates in that same step. When both sides access the block in one cycle, the model applies the clearing effects first and the setting effects second. This matches the collision rules in R10 and R11.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;

    typedef enum logic [2:0] {
        K_TX,
        K_RX,
        K_STAT,
        K_CTRL,
        K_GPREQ,
        K_NONE
    } reg_kind_e;

    // Map a word address onto a register kind for a given channel count.
    function automatic reg_kind_e decode_kind(input int unsigned a, input int unsigned nch);
        if (a < nch)                 return K_TX;
        else if (a < 2 * nch)        return K_RX;
        else if (a == 2 * nch)       return K_STAT;
        else if (a == 2 * nch + 1)   return K_CTRL;
        else if (a == 2 * nch + 2)   return K_GPREQ;
        else                         return K_NONE;
    endfunction

endpackage

// File: rtl/ipcmb_chan.sv
// One direction of mailbox words plus their occupancy bits.
module ipcmb_chan #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          wr,
    input  logic [DW-1:0]           wdata,
    input  logic [NCH-1:0]          rd,
    output logic [NCH-1:0][DW-1:0]  data,
    output logic [NCH-1:0]          full
);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        logic [NCH-1:0]         full;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            if (wr[n]) begin
                // a write in the same cycle as a drain leaves the slot full
                st_d.data[n] = wdata;
                st_d.full[n] = 1'b1;
            end else if (rd[n]) begin
                st_d.full[n] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;

endmodule

// File: rtl/ipcmb_side.sv
// Register port of one processor: decode, control, pending requests, read mux, interrupt.
module ipcmb_side
    import ipcmb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int NFL = 3,
    parameter int NGP = 4,
    parameter int AW  = 4,
    localparam int CW = 2 * NCH + NGP + NFL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [CW-1:0]           cfg_wdata,
    output logic [DW-1:0]           rdata,
    input  logic [NCH-1:0][DW-1:0]  tx_data,
    input  logic [NCH-1:0]          tx_full,
    input  logic [NCH-1:0][DW-1:0]  rx_data,
    input  logic [NCH-1:0]          rx_full,
    input  logic [NFL-1:0]          peer_flags,
    input  logic [NGP-1:0]          gp_in,
    output logic [NCH-1:0]          tx_wr,
    output logic [NCH-1:0]          rx_rd,
    output logic [NGP-1:0]          gp_out,
    output logic [NFL-1:0]          flags,
    output logic                    irq,
    output logic                    wake
);

    typedef struct packed {
        logic [NFL-1:0] flags;
        logic [NGP-1:0] gp_ie;
        logic [NCH-1:0] rx_ie;
        logic [NCH-1:0] tx_ie;
        logic [NGP-1:0] pend;
    } side_state_t;

    side_state_t    st_d, st_q;
    reg_kind_e      kind;
    logic           wr_hit, rd_hit;
    logic [NGP-1:0] clr;
    logic [CW-1:0]  ctrl_word, stat_word;

    always_comb begin
        kind   = decode_kind(int'(addr), NCH);
        wr_hit = req & we;
        rd_hit = req & ~we;

        for (int n = 0; n < NCH; n++) begin
            tx_wr[n] = wr_hit && (kind == K_TX) && (addr == AW'(n));
            rx_rd[n] = rd_hit && (kind == K_RX) && (addr == AW'(NCH + n));
        end

        gp_out = (wr_hit && kind == K_GPREQ) ? cfg_wdata[NGP-1:0]      : '0;
        clr    = (wr_hit && kind == K_STAT)  ? cfg_wdata[2*NCH +: NGP] : '0;

        st_d = st_q;
        if (wr_hit && kind == K_CTRL)
            {st_d.flags, st_d.gp_ie, st_d.rx_ie, st_d.tx_ie} = cfg_wdata;
        // a new request wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | gp_in;

        ctrl_word = {st_q.flags, st_q.gp_ie, st_q.rx_ie, st_q.tx_ie};
        stat_word = {peer_flags, st_q.pend, rx_full, ~tx_full};

        rdata = '0;
        if (rd_hit) begin
            unique case (kind)
                K_TX: for (int n = 0; n < NCH; n++)
                          if (addr == AW'(n)) rdata = tx_data[n];
                K_RX: for (int n = 0; n < NCH; n++)
                          if (addr == AW'(NCH + n)) rdata = rx_data[n];
                K_STAT: rdata[CW-1:0] = stat_word;
                K_CTRL: rdata[CW-1:0] = ctrl_word;
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign wake  = |st_q.pend;
    assign irq   = |(~tx_full & st_q.tx_ie) | |(rx_full & st_q.rx_ie) | |(st_q.pend & st_q.gp_ie);

endmodule

// File: rtl/ipc_mailbox.sv
// Two symmetric register ports joined by two crossed channel banks.
module ipc_mailbox #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int NFL = 3,
    parameter int NGP = 4,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_req,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    output logic          a_wake,
    input  logic          b_req,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq,
    output logic          b_wake
);

    localparam int CW = 2 * NCH + NGP + NFL;

    logic [NCH-1:0][DW-1:0] ab_data, ba_data;
    logic [NCH-1:0]         ab_full, ba_full;
    logic [NCH-1:0]         a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
    logic [NGP-1:0]         a_gp, b_gp;
    logic [NFL-1:0]         a_flags, b_flags;

    ipcmb_chan #(.NCH(NCH), .DW(DW)) u_ab (
        .clk(clk), .rst_n(rst_n), .wr(a_tx_wr), .wdata(a_wdata),
        .rd(b_rx_rd), .data(ab_data), .full(ab_full)
    );

    ipcmb_chan #(.NCH(NCH), .DW(DW)) u_ba (
        .clk(clk), .rst_n(rst_n), .wr(b_tx_wr), .wdata(b_wdata),
        .rd(a_rx_rd), .data(ba_data), .full(ba_full)
    );

    ipcmb_side #(.NCH(NCH), .DW(DW), .NFL(NFL), .NGP(NGP), .AW(AW)) u_side_a (
        .clk(clk), .rst_n(rst_n), .req(a_req), .we(a_we), .addr(a_addr),
        .cfg_wdata(a_wdata[CW-1:0]), .rdata(a_rdata),
        .tx_data(ab_data), .tx_full(ab_full), .rx_data(ba_data), .rx_full(ba_full),
        .peer_flags(b_flags), .gp_in(b_gp),
        .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .gp_out(a_gp), .flags(a_flags),
        .irq(a_irq), .wake(a_wake)
    );

    ipcmb_side #(.NCH(NCH), .DW(DW), .NFL(NFL), .NGP(NGP), .AW(AW)) u_side_b (
        .clk(clk), .rst_n(rst_n), .req(b_req), .we(b_we), .addr(b_addr),
        .cfg_wdata(b_wdata[CW-1:0]), .rdata(b_rdata),
        .tx_data(ba_data), .tx_full(ba_full), .rx_data(ab_data), .rx_full(ab_full),
        .peer_flags(a_flags), .gp_in(a_gp),
        .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .gp_out(b_gp), .flags(b_flags),
        .irq(b_irq), .wake(b_wake)
    );

endmodule

// File: rtl/ipcmb_checker.sv
module ipcmb_checker #(
    parameter int NCH = 4,
    parameter int NGP = 4,
    parameter int AW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a_req,
    input logic           a_we,
    input logic [AW-1:0]  a_addr,
    input logic [NGP-1:0] a_gpw,
    input logic           b_req,
    input logic           b_we,
    input logic [AW-1:0]  b_addr,
    input logic [NGP-1:0] b_gpw,
    input logic [NCH-1:0] ab_full,
    input logic [NCH-1:0] ba_full,
    input logic           a_wake,
    input logic           b_wake
);

    localparam logic [AW-1:0] GPA = AW'(2 * NCH + 2);

    AST_GP_WAKE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && b_we && b_addr == GPA && b_gpw != '0) |=> a_wake);  // R8
    AST_GP_WAKE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && a_addr == GPA && a_gpw != '0) |=> b_wake);  // R8

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [AW-1:0] TXA = AW'(n);
        localparam logic [AW-1:0] RXA = AW'(NCH + n);

        AST_WR_FILLS_AB: assert property (@(posedge clk) disable iff (!rst_n)
            (a_req && a_we && a_addr == TXA) |=> ab_full[n]);  // R3
        AST_WR_FILLS_BA: assert property (@(posedge clk) disable iff (!rst_n)
            (b_req && b_we && b_addr == TXA) |=> ba_full[n]);  // R3
        AST_RD_DRAINS_AB: assert property (@(posedge clk) disable iff (!rst_n)
            (b_req && !b_we && b_addr == RXA && !(a_req && a_we && a_addr == TXA)) |=> !ab_full[n]);  // R4
        AST_RD_DRAINS_BA: assert property (@(posedge clk) disable iff (!rst_n)
            (a_req && !a_we && a_addr == RXA && !(b_req && b_we && b_addr == TXA)) |=> !ba_full[n]);  // R4
        AST_FILL_CAUSE_AB: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ab_full[n]) |-> $past(a_req && a_we && a_addr == TXA));  // R3
        AST_DRAIN_CAUSE_AB: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ab_full[n]) |-> $past(b_req && !b_we && b_addr == RXA));  // R4
    end

endmodule

bind ipc_mailbox ipcmb_checker #(.NCH(NCH), .NGP(NGP), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_gpw(a_wdata[NGP-1:0]),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_gpw(b_wdata[NGP-1:0]),
    .ab_full(ab_full), .ba_full(ba_full), .a_wake(a_wake), .b_wake(b_wake)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, a_wake, b_irq, b_wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq), .a_wake(a_wake),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_wake(b_wake)
    );

    // reference model
    logic [31:0] m_ab [4];
    logic [31:0] m_ba [4];
    logic [3:0]  f_ab = 0, f_ba = 0, p_a = 0, p_b = 0;
    logic [14:0] c_a = 0, c_b = 0;

    function automatic logic [31:0] exp_rd(input bit s, input logic [3:0] ad);
        logic [31:0] r = 0;
        if (ad < 4)       r = s ? m_ba[ad[1:0]] : m_ab[ad[1:0]];
        else if (ad < 8)  r = s ? m_ab[ad[1:0]] : m_ba[ad[1:0]];
        else if (ad == 8) r = s ? {17'd0, c_a[14:12], p_b, f_ab, ~f_ba}
                                : {17'd0, c_b[14:12], p_a, f_ba, ~f_ab};
        else if (ad == 9) r = {17'd0, s ? c_b : c_a};
        return r;
    endfunction

    function automatic logic exp_irq(input bit s);
        if (!s) return |(~f_ab & c_a[3:0]) | |(f_ba & c_a[7:4]) | |(p_a & c_a[11:8]);
        else    return |(~f_ba & c_b[3:0]) | |(f_ab & c_b[7:4]) | |(p_b & c_b[11:8]);
    endfunction

    function automatic string kind_tag(input logic [3:0] ad);
        if (ad < 8)  return "R2";
        if (ad == 8) return "R3";
        if (ad == 9) return "R7";
        return "R12";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic upd(input bit s, input bit ph, input bit we, input logic [3:0] ad, input logic [31:0] wd);
        if (!ph) begin
            if (!we && ad >= 4 && ad < 8) begin
                if (!s) f_ba[ad[1:0]] = 1'b0; else f_ab[ad[1:0]] = 1'b0;
            end
            if (we && ad == 8) begin
                if (!s) p_a = p_a & ~wd[11:8]; else p_b = p_b & ~wd[11:8];
            end
            if (we && ad == 9) begin
                if (!s) c_a = wd[14:0]; else c_b = wd[14:0];
            end
        end else begin
            if (we && ad < 4) begin
                if (!s) begin m_ab[ad[1:0]] = wd; f_ab[ad[1:0]] = 1'b1; end
                else    begin m_ba[ad[1:0]] = wd; f_ba[ad[1:0]] = 1'b1; end
            end
            if (we && ad == 10) begin
                if (!s) p_b = p_b | wd[3:0]; else p_a = p_a | wd[3:0];
            end
        end
    endtask

    // one bus cycle, optionally on both sides at once
    task automatic cyc(input bit ea, input bit wa, input logic [3:0] aa, input logic [31:0] da,
                       input bit eb, input bit wb, input logic [3:0] ab, input logic [31:0] db,
                       input string tag);
        logic [31:0] xa, xb, ra, rb;
        xa = exp_rd(0, aa);
        xb = exp_rd(1, ab);
        @(negedge clk);
        a_req = ea; a_we = wa; a_addr = aa; a_wdata = da;
        b_req = eb; b_we = wb; b_addr = ab; b_wdata = db;
        #1;
        ra = a_rdata; rb = b_rdata;
        if (ea && !wa) chk({tag, " A read"}, ra, xa);
        if (eb && !wb) chk({tag, " B read"}, rb, xb);
        @(posedge clk);
        #1;
        a_req = 0; b_req = 0; a_we = 0; b_we = 0;
        if (ea) upd(0, 0, wa, aa, da);
        if (eb) upd(1, 0, wb, ab, db);
        if (ea) upd(0, 1, wa, aa, da);
        if (eb) upd(1, 1, wb, ab, db);
        chk("R5/R6/R9 irq A", {31'd0, a_irq}, {31'd0, exp_irq(0)});
        chk("R5/R6/R9 irq B", {31'd0, b_irq}, {31'd0, exp_irq(1)});
        chk("R8 wake A", {31'd0, a_wake}, {31'd0, |p_a});
        chk("R8 wake B", {31'd0, b_wake}, {31'd0, |p_b});
    endtask

    task automatic ra_(input logic [3:0] ad, input string tag);
        cyc(1, 0, ad, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rb_(input logic [3:0] ad, input string tag);
        cyc(0, 0, 0, 0, 1, 0, ad, 0, tag);
    endtask
    task automatic wa_(input logic [3:0] ad, input logic [31:0] d, input string tag);
        cyc(1, 1, ad, d, 0, 0, 0, 0, tag);
    endtask
    task automatic wb_(input logic [3:0] ad, input logic [31:0] d, input string tag);
        cyc(0, 0, 0, 0, 1, 1, ad, d, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1CE5_0A7B));
        for (int i = 0; i < 4; i++) begin m_ab[i] = 0; m_ba[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq A", {31'd0, a_irq}, 32'd0);
        chk("R1 wake B", {31'd0, b_wake}, 32'd0);
        ra_(8, "R1 status");
        chk("R1 status value A", exp_rd(0, 8), 32'h0000_000F);
        rb_(8, "R1 status B");
        rb_(9, "R1 ctrl B");

        // R2/R3/R4 A->B channel 1, then B->A channel 3
        wa_(1, 32'hA5A5_0001, "R3 write");
        ra_(8, "R3 sender status");
        rb_(8, "R3 receiver status");
        rb_(5, "R2 cross read");
        rb_(8, "R4 receiver status");
        ra_(8, "R4 sender status");
        wb_(3, 32'h1234_5678, "R3 write B");
        ra_(7, "R2 cross read B->A");
        ra_(1, "R2 own tx readback");

        // R5 receive interrupt at B, R6 transmit interrupt at A
        wb_(9, 32'h0000_0010, "R5 enable");
        wa_(0, 32'hDEAD_0000, "R5 fill");
        chk("R5 irq B raised", {31'd0, b_irq}, 32'd1);
        rb_(4, "R5 drain");
        chk("R5 irq B dropped", {31'd0, b_irq}, 32'd0);
        wa_(9, 32'h0000_0004, "R6 enable");
        chk("R6 irq A while empty", {31'd0, a_irq}, 32'd1);
        wa_(2, 32'h0000_0022, "R6 fill");
        chk("R6 irq A cleared", {31'd0, a_irq}, 32'd0);

        // R7 flags
        wa_(9, 32'h0000_5004, "R7 set flags");
        rb_(8, "R7 peer flags");

        // R10 collision: channel 2 full with old word
        cyc(1, 1, 2, 32'h0000_0033, 1, 0, 6, 0, "R10 collide");
        rb_(8, "R10 still full");
        rb_(6, "R10 new word");

        // R8/R9/R11 general-purpose requests
        wa_(10, 32'h0000_0005, "R8 request");
        chk("R8 wake B set", {31'd0, b_wake}, 32'd1);
        wb_(9, 32'h0000_0400, "R9 enable gp2");
        chk("R9 irq B", {31'd0, b_irq}, 32'd1);
        cyc(1, 1, 10, 32'h1, 1, 1, 8, 32'h0000_0100, "R11 clear and set");
        rb_(8, "R11 pending kept");
        wb_(8, 32'h0000_0500, "R8 clear");
        chk("R8 wake B clear", {31'd0, b_wake}, 32'd0);

        // R12 ignored writes and unmapped reads
        wb_(4, 32'hFFFF_FFFF, "R12 write rx");
        rb_(4, "R12 rx unchanged");
        rb_(8, "R12 status unchanged");
        ra_(12, "R12 unmapped");
        ra_(10, "R12 gpreq reads zero");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit ea, eb, wa, wb;
            logic [3:0] aa, ab;
            logic [31:0] da, db;
            ea = 1'($urandom_range(0, 1));
            eb = 1'($urandom_range(0, 1));
            wa = 1'($urandom_range(0, 1));
            wb = 1'($urandom_range(0, 1));
            aa = 4'($urandom_range(0, 12));
            ab = 4'($urandom_range(0, 12));
            da = $urandom;
            db = $urandom;
            cyc(ea, wa, aa, da, eb, wb, ab, db, kind_tag(ea ? aa : ab));
        end

        finish_run();
    end

endmodule